// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked request port to an external asynchronous static RAM of one million 4-bit words. A client presents an address, a direction flag and, for stores, a data nibble, then raises a request while the controller shows ready. The controller drives the memory's active-low select, output-enable and write-strobe lines, the address bus and a split data path: an outgoing nibble with its own drive enable, plus the incoming nibble. Loads come back on a read-data register with a one-cycle valid strobe.

Every minimum interval the memory needs is expressed in nanoseconds and turned into a cycle count from the clock period. Each count is the ceiling of the division, with a floor of one cycle. All pin outputs come from flops. Output enable stays high for the whole of a store, so the two sides never drive the data bus at the same time.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, ready_o is 1, sram_ce_no, sram_oe_no and sram_we_no are 1, and sram_dq_oe_o and rd_valid_o are 0.
- R2: ready_o is 1 only when the controller is idle. A request seen while ready_o is 1 is accepted, and ready_o is 0 in the next cycle.
- R3: A load holds select and output enable low and the write strobe high for RD_CYC cycles (3 by default). The data pins are sampled at the edge that closes this window. rd_valid_o is then 1 for exactly one cycle, with rdata_o holding the stored nibble, and ready_o is already 1 in that cycle.
- R4: A store lowers select first. The write strobe falls SETUP_CYC cycles later (2 by default) and stays low for PULSE_CYC cycles (2 by default). The write strobe, and never select, ends the store: select is still low when the strobe rises.
- R5: The data drive enable rises with the write strobe's falling edge and falls one cycle after the strobe rises. The outgoing data and the address do not change while the drive is on.
- R6: Output enable is 1 during every store. The drive enable is never 1 while output enable is 0, and output enable and the write strobe are never both 0.
- R7: The data drive starts no sooner than SETUP_CYC cycles after output enable last rose. At least one idle cycle with the drive off comes before output enable falls again.
- R8: Each count is ceil(ns / CLK_PERIOD_NS), with a minimum of 1. A store lasts SETUP_CYC + PULSE_CYC + REC_CYC cycles (2+2+1 = 5 by default), and REC_CYC is large enough to cover the full write-cycle time. A load lasts RD_CYC cycles.
- R9: A request raised while ready_o is 0 is ignored. The address on the pins does not change, and no access to the requested address ever takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| ready_o | output | 1 | Idle; a request is accepted |
| wr_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 20 | Word address |
| wdata_i | input | 4 | Store data |
| rdata_o | output | 4 | Load data |
| rd_valid_o | output | 1 | One-cycle pulse: rdata_o valid |
| sram_addr_o | output | 20 | Memory address bus |
| sram_ce_no | output | 1 | Memory select, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_dq_o | output | 4 | Outgoing data nibble |
| sram_dq_oe_o | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | 4 | Incoming data nibble |

## Verification
The hardest case to reach from the ports is a load that directly follows a store, or a store that directly follows a load. In both cases the bus changes hands, and the release and turnaround intervals are at their shortest. The bench issues each new request in the same cycle that ready_o returns, both in directed pairs and across a long random mix. A behavioural memory model corrupts any data sampled earlier than the access time, and it times the strobe width, data setup and bus release in nanoseconds. A second hard case is a request that arrives mid-access to a fresh address; the bench reads that address afterwards to confirm nothing was stored there.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } state_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            st_d_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  // pins follow the next state so they switch on the same edge as the FSM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      we_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_n_o  <= (st_d_i == ST_IDLE);
      oe_n_o  <= (st_d_i != ST_RD_ACCESS);
      we_n_o  <= (st_d_i != ST_WR_PULSE);
      dq_oe_o <= (st_d_i == ST_WR_PULSE) || (st_d_i == ST_WR_RECOVER);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      dq_o   <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      dq_o   <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_DOE_NS      = 5,
  parameter int unsigned T_HZOE_NS     = 5,
  parameter int unsigned T_PWE_NS      = 7,
  parameter int unsigned T_SD_NS       = 5,
  parameter int unsigned T_AW_NS       = 7,
  parameter int unsigned T_WC_NS       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned RD_CYC    = umax(ns2cyc(T_AA_NS, CLK_PERIOD_NS),
                                           ns2cyc(T_DOE_NS, CLK_PERIOD_NS));
  localparam int unsigned SETUP_CYC = ns2cyc(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = umax(umax(ns2cyc(T_PWE_NS, CLK_PERIOD_NS),
                                                ns2cyc(T_SD_NS, CLK_PERIOD_NS)),
                                           ns2cyc(T_AW_NS, CLK_PERIOD_NS));
  localparam int unsigned WC_CYC    = ns2cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC   = (WC_CYC > SETUP_CYC + PULSE_CYC + 1) ?
                                      WC_CYC - SETUP_CYC - PULSE_CYC : 1;
  localparam int unsigned MAX_CYC   = umax(umax(RD_CYC, SETUP_CYC), umax(PULSE_CYC, REC_CYC));
  localparam int unsigned CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  state_e           state_q, state_d;
  logic             t_load, t_done, accept;
  logic [CNT_W-1:0] t_val;
  logic [DATA_W-1:0] rdata_q;
  logic             rd_valid_q;

  assign accept  = (state_q == ST_IDLE) && req_i;
  assign ready_o = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        t_load = 1'b1;
        if (wr_i) begin
          state_d = ST_WR_SETUP;
          t_val   = CNT_W'(SETUP_CYC - 1);
        end else begin
          state_d = ST_RD_ACCESS;
          t_val   = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD_ACCESS: if (t_done) state_d = ST_IDLE;
      ST_WR_SETUP: if (t_done) begin
        state_d = ST_WR_PULSE;
        t_load  = 1'b1;
        t_val   = CNT_W'(PULSE_CYC - 1);
      end
      ST_WR_PULSE: if (t_done) begin
        state_d = ST_WR_RECOVER;
        t_load  = 1'b1;
        t_val   = CNT_W'(REC_CYC - 1);
      end
      ST_WR_RECOVER: if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // capture on the edge closing the access window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      rd_valid_q <= (state_q == ST_RD_ACCESS) && t_done;
      if ((state_q == ST_RD_ACCESS) && t_done) rdata_q <= sram_dq_i;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rd_valid_q;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  sram_ctrl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .st_d_i  (state_d),
    .load_i  (accept),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ce_n_o  (sram_ce_no),
    .oe_n_o  (sram_oe_no),
    .we_n_o  (sram_we_no),
    .addr_o  (sram_addr_o),
    .dq_o    (sram_dq_o),
    .dq_oe_o (sram_dq_oe_o)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned T_HZOE_NS     = 5,
  parameter int unsigned T_PWE_NS      = 7,
  parameter int unsigned T_SD_NS       = 5,
  parameter int unsigned T_AW_NS       = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_dq_oe_o
);
  localparam int unsigned SETUP_CYC = ns2cyc(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = umax(umax(ns2cyc(T_PWE_NS, CLK_PERIOD_NS),
                                                ns2cyc(T_SD_NS, CLK_PERIOD_NS)),
                                           ns2cyc(T_AW_NS, CLK_PERIOD_NS));

  logic [7:0] we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= '0;
    end else begin
      we_lo_cnt <= !sram_we_no ? ((we_lo_cnt == 8'hff) ? we_lo_cnt : we_lo_cnt + 1'b1) : '0;
      oe_hi_cnt <= sram_oe_no  ? ((oe_hi_cnt == 8'hff) ? oe_hi_cnt : oe_hi_cnt + 1'b1) : '0;
    end
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
  assert_valid_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ready_o);
  assert_we_in_ce_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);
  assert_we_ends_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> !sram_ce_no);
  assert_we_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_lo_cnt >= PULSE_CYC));
  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);
  assert_drive_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> ($stable(sram_dq_o) && $stable(sram_addr_o)));
  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);
  assert_oe_we_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_oe_no || sram_we_no));
  assert_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (oe_hi_cnt >= SETUP_CYC));
  assert_busy_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .T_HZOE_NS     (T_HZOE_NS),
  .T_PWE_NS      (T_PWE_NS),
  .T_SD_NS       (T_SD_NS),
  .T_AW_NS       (T_AW_NS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ready_o      (ready_o),
  .rd_valid_o   (rd_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_ce_no   (sram_ce_no),
  .sram_oe_no   (sram_oe_no),
  .sram_we_no   (sram_we_no),
  .sram_dq_o    (sram_dq_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
  localparam logic [19:0] JUNK = 20'hABCDE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [19:0] addr = '0;
  logic [3:0]  wdata = '0;
  logic        ready, rd_valid;
  logic [3:0]  rdata;
  logic [19:0] sram_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [3:0]  dq_o;
  logic [3:0]  dq_i = '0;

  int n_chk = 0, n_fail = 0;
  int v_contend = 0, v_wtime = 0, v_hold = 0, v_turn = 0;
  bit done = 1'b0;

  logic [3:0] mem [int];
  logic [3:0] ref_mem [int];
  realtime t_chg = 0, t_we_fall = 0, t_dq = 0, t_addr = 0, t_oe_rise = 0;

  always #2 clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .sram_addr_o(sram_addr), .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n),
    .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // behavioural memory
  always @(sram_addr or ce_n or oe_n) t_chg = $realtime;
  always @(sram_addr) t_addr = $realtime;
  always @(dq_o or dq_oe) t_dq = $realtime;
  always @(negedge we_n) t_we_fall = $realtime;
  always @(posedge oe_n) t_oe_rise = $realtime;

  always @(negedge clk) begin
    logic [3:0] v;
    v = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 4'h0;
    if (!ce_n && !oe_n && we_n) dq_i = ($realtime - t_chg >= 10.0) ? v : ~v;
    else dq_i = 4'h0;
    if (rst_n && dq_oe && !ce_n && !oe_n) v_contend++;
    if (rst_n && !oe_n && !we_n) v_contend++;
  end

  always @(posedge we_n) begin
    if (rst_n && !ce_n) begin
      if ($realtime - t_we_fall < 7.0) v_wtime++;
      if ($realtime - t_dq < 5.0) v_wtime++;
      if ($realtime - t_addr < 7.0) v_wtime++;
      if (!dq_oe) v_hold++;
      mem[int'(sram_addr)] = dq_o;
    end
  end

  always @(posedge dq_oe) if (rst_n && ($realtime - t_oe_rise < 5.0)) v_turn++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [3:0] ref_rd(input logic [19:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
  endfunction

  function automatic logic [19:0] pool(input int i);
    if (i == 0)  return 20'h00000;
    if (i == 15) return 20'hFFFFF;
    return 20'(i * 20'h11111);
  endfunction

  // called at a negedge with ready high; returns at the negedge where ready is back
  task automatic access(input bit w, input logic [19:0] a, input logic [3:0] d, input bit poke);
    int busy = 0;
    int addr_bad = 0;
    logic [3:0] exp;
    exp = ref_rd(a);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(!ready, "R2 ready low after accept", ready, 0);
    while (!ready) begin
      busy++;
      if (!ce_n && sram_addr != a) addr_bad++;
      if (poke && busy == 2) begin
        req = 1'b1; wr = 1'b1; addr = JUNK; wdata = ~d;
      end else req = 1'b0;
      @(negedge clk);
      if (busy > 20) break;
    end
    req = 1'b0;
    chk(addr_bad == 0, "R9 address held while busy", addr_bad, 0);
    if (w) begin
      ref_mem[int'(a)] = d;
      chk(busy == 5, "R8 store length", busy, 5);
    end else begin
      chk(busy == 3, "R8 load length", busy, 3);
      chk(rd_valid == 1'b1, "R3 valid pulse", rd_valid, 1);
      chk(rdata == exp, "R3 load data", rdata, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(ce_n && oe_n && we_n, "R1 strobes high", {ce_n, oe_n, we_n}, 7);
    chk(!dq_oe, "R1 drive off", dq_oe, 0);
    chk(!rd_valid, "R1 valid low", rd_valid, 0);

    // directed: turnarounds back to back, address extremes
    access(1'b0, 20'hFFFFF, 4'h0, 1'b0);
    access(1'b1, 20'h00000, 4'h5, 1'b0);
    access(1'b0, 20'h00000, 4'h0, 1'b0);
    access(1'b1, 20'hFFFFF, 4'hA, 1'b0);
    access(1'b0, 20'hFFFFF, 4'h0, 1'b0);
    @(negedge clk);
    chk(!rd_valid, "R3 valid lasts one cycle", rd_valid, 0);
    chk(oe_n, "R6 oe high when idle", oe_n, 1);

    // R9: request during a busy store must be dropped
    access(1'b1, 20'h12345, 4'h9, 1'b1);
    access(1'b0, JUNK, 4'h0, 1'b0);
    access(1'b0, 20'h12345, 4'h0, 1'b0);
    access(1'b0, 20'h54321, 4'h0, 1'b1);
    access(1'b0, JUNK, 4'h0, 1'b0);

    // random mix
    for (int i = 0; i < 160; i++) begin
      logic [19:0] a;
      a = pool(int'($urandom % 16));
      if ($urandom % 2) access(1'b1, a, 4'($urandom), 1'b0);
      else              access(1'b0, a, 4'h0, 1'b0);
      if (($urandom % 4) == 0) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    chk(v_contend == 0, "R6 bus contention", v_contend, 0);
    chk(v_wtime == 0, "R4 strobe/setup timing", v_wtime, 0);
    chk(v_hold == 0, "R5 drive held to strobe end", v_hold, 0);
    chk(v_turn == 0, "R7 bus turnaround", v_turn, 0);
    summary();
  end
endmodule